// File: doc/BRIEF.md
# Segment Line Capture with Cascade Hand-off

This block is the input side of one column driver in a chain of drivers. Display data arrives on a parallel bus, qualified by a data strobe. The bus is either 4 bits wide, so two strobes make one byte, or 8 bits wide, so one strobe makes one byte. The block packs the data into bytes and writes each byte into a 160-bit line buffer. A one-hot group pointer chooses where each byte goes. The pointer has ten positions of 16 bits each, and it moves on after every second byte. A direction input chooses whether the pointer walks the groups upward or downward.

A line-latch pulse does two things. It copies the finished buffer into the output latch, and it arms the block for the next line. The block becomes selected when the chain enable input is high while it is armed. It then stays selected until it has taken exactly 160 bits. At that point it raises its cascade output, which hands the bus to the next driver in the chain, and it deselects itself. Strobes that arrive while the block is not selected have no effect.

Top module: `col_line_capture`

## Requirements
- R1: After reset, `line_q` is all zeros and `cascade_out` is 0.
- R2: In wide mode (`wide_mode`=1), each accepted strobe delivers one byte, `din[7:0]`.
- R3: In narrow mode (`wide_mode`=0), two accepted strobes form one byte. The first strobe supplies bits [3:0] of the byte from `din[3:0]`, and the second supplies bits [7:4] from `din[3:0]`. `din[7:4]` is ignored in this mode.
- R4: With `rev_dir`=0, byte k of a line (k = 0..19) is stored at `line_q` bits [16*(k/2) + 8*(k%2) +: 8].
- R5: With `rev_dir`=1, byte k is stored at bits [16*(9 - k/2) + 8*(k%2) +: 8].
- R6: `cascade_out` goes high one clock after the strobe that completes the 20th byte of a line, and not before. After that, the block ignores further strobes.
- R7: While the block is armed, strobes have no effect until `chip_en_in` is high. A strobe in the same cycle that `chip_en_in` first goes high is accepted. Strobes before any line-latch pulse also have no effect.
- R8: A `line_latch` pulse makes `line_q` equal to the buffer from the next clock onward, and `line_q` otherwise holds its value. The same pulse clears `cascade_out`, restarts the pointer at the first group for the current direction, and discards a pending half byte.
- R9: A strobe in the same cycle as `line_latch` is ignored.
- R10: Once the block is selected, dropping `chip_en_in` does not stop the capture of the remaining bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_latch | input | 1 | Line-latch pulse: transfer buffer, re-arm |
| chip_en_in | input | 1 | Chain enable from the previous driver |
| data_stb | input | 1 | Data strobe, one per bus transfer |
| wide_mode | input | 1 | 1 = 8-bit bus, 0 = 4-bit bus |
| rev_dir | input | 1 | 1 = pointer walks groups downward |
| din | input | 8 | Parallel display data |
| cascade_out | output | 1 | Enable for the next driver, registered |
| line_q | output | 160 | Output line latch |

## Verification
On every cycle, the assertions check four things: the group pointer never holds more than one bit, it moves only when a byte is written, `cascade_out` never coincides with selection, and `line_q` changes only after a line-latch pulse. Only the bench scenarios can show the rest. These are byte placement in both directions and both bus widths, the exact cycle in which the cascade rises after the 20th byte, and the rejection of strobes before enable, after completion and alongside a line-latch pulse. They also include the discarding of a stray half byte and the continued capture after the enable drops.

// File: rtl/col_cap_pkg.sv
package col_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_DONE   = 2'd3
  } cap_state_t;
endpackage

// File: rtl/nib_packer.sv
module nib_packer #(
  parameter int BYTE_W = 8,
  localparam int NIB_W = BYTE_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic              wide_mode,
  input  logic [BYTE_W-1:0] din,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data
);
  logic             phase_q;
  logic [NIB_W-1:0] low_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase_q <= 1'b0;
      low_q   <= '0;
    end else if (take && !wide_mode) begin
      if (!phase_q) begin
        low_q   <= din[NIB_W-1:0];
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
      end
    end
  end

  always_comb begin
    byte_vld  = take && (wide_mode || phase_q);
    byte_data = wide_mode ? din : {din[NIB_W-1:0], low_q};
  end

  // R3: a byte is never emitted in narrow mode without a held first nibble
  assert_narrow_pair_R3: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !wide_mode) |-> phase_q);
endmodule

// File: rtl/sel_ctrl.sv
module sel_ctrl
  import col_cap_pkg::*;
#(
  parameter int LINE_W  = 160,
  parameter int BYTE_W  = 8,
  parameter int GROUP_W = 16,
  localparam int NGRP   = LINE_W / GROUP_W,
  localparam int NBYTES = LINE_W / BYTE_W,
  localparam int CNT_W  = $clog2(NBYTES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_latch,
  input  logic            chip_en_in,
  input  logic            rev_dir,
  input  logic            byte_vld,
  output logic            selected,
  output logic [NGRP-1:0] ptr,
  output logic            half,
  output logic            cascade_out
);
  cap_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NGRP-1:0]  start_ptr;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  always_comb begin
    start_ptr = rev_dir ? {1'b1, {(NGRP-1){1'b0}}} : {{(NGRP-1){1'b0}}, 1'b1};
    selected  = !line_latch &&
                ((st_q == ST_ACTIVE) || ((st_q == ST_ARMED) && chip_en_in));
    half      = cnt_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      ptr         <= {{(NGRP-1){1'b0}}, 1'b1};
      cnt_q       <= '0;
      cascade_out <= 1'b0;
    end else if (line_latch) begin
      st_q        <= ST_ARMED;
      ptr         <= start_ptr;
      cnt_q       <= '0;
      cascade_out <= 1'b0;
    end else begin
      if (st_q == ST_ARMED && chip_en_in) st_q <= ST_ACTIVE;
      if (byte_vld) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q[0]) ptr <= rev_dir ? (ptr >> 1) : (ptr << 1);
        if (cnt_q == LAST) begin
          st_q        <= ST_DONE;
          cascade_out <= 1'b1;
        end
      end
    end
  end

  assert_ptr_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ptr));
  assert_casc_desel_R6: assert property (@(posedge clk) disable iff (rst)
    cascade_out |-> !selected);
  assert_latch_clear_R8: assert property (@(posedge clk) disable iff (rst)
    line_latch |=> (!cascade_out && cnt_q == '0));
  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!byte_vld && !line_latch) |=> $stable(ptr));
endmodule

// File: rtl/line_store.sv
module line_store #(
  parameter int LINE_W  = 160,
  parameter int BYTE_W  = 8,
  parameter int GROUP_W = 16,
  localparam int NGRP   = LINE_W / GROUP_W,
  localparam int NBYTES = LINE_W / BYTE_W,
  localparam int BPG    = GROUP_W / BYTE_W,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_latch,
  input  logic              wr_en,
  input  logic [NGRP-1:0]   ptr,
  input  logic              half,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [LINE_W-1:0] line_q
);
  logic [BYTE_W-1:0] mem [NBYTES];
  logic [LINE_W-1:0] flat;
  logic [IDX_W-1:0]  wr_idx;

  always_comb begin
    wr_idx = '0;
    for (int g = 0; g < NGRP; g++)
      if (ptr[g]) wr_idx = IDX_W'(g * BPG) | IDX_W'(half);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= '0;
    end else if (wr_en && (ptr != '0)) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_flat
    assign flat[i*BYTE_W +: BYTE_W] = mem[i];
  end

  always_ff @(posedge clk) begin
    if (rst)             line_q <= '0;
    else if (line_latch) line_q <= flat;
  end

  assert_line_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !line_latch |=> $stable(line_q));
endmodule

// File: rtl/col_line_capture.sv
module col_line_capture #(
  parameter int LINE_W  = 160,
  parameter int BYTE_W  = 8,
  parameter int GROUP_W = 16,
  localparam int NGRP   = LINE_W / GROUP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_latch,
  input  logic              chip_en_in,
  input  logic              data_stb,
  input  logic              wide_mode,
  input  logic              rev_dir,
  input  logic [BYTE_W-1:0] din,
  output logic              cascade_out,
  output logic [LINE_W-1:0] line_q
);
  logic              selected, take, byte_vld, half;
  logic [BYTE_W-1:0] byte_data;
  logic [NGRP-1:0]   ptr;

  assign take = data_stb && selected;

  nib_packer #(.BYTE_W(BYTE_W)) u_pack (
    .clk(clk), .rst(rst), .clr(line_latch), .take(take),
    .wide_mode(wide_mode), .din(din),
    .byte_vld(byte_vld), .byte_data(byte_data)
  );

  sel_ctrl #(.LINE_W(LINE_W), .BYTE_W(BYTE_W), .GROUP_W(GROUP_W)) u_sel (
    .clk(clk), .rst(rst), .line_latch(line_latch), .chip_en_in(chip_en_in),
    .rev_dir(rev_dir), .byte_vld(byte_vld), .selected(selected),
    .ptr(ptr), .half(half), .cascade_out(cascade_out)
  );

  line_store #(.LINE_W(LINE_W), .BYTE_W(BYTE_W), .GROUP_W(GROUP_W)) u_store (
    .clk(clk), .rst(rst), .line_latch(line_latch), .wr_en(byte_vld),
    .ptr(ptr), .half(half), .wr_data(byte_data), .line_q(line_q)
  );

  // R9: nothing is accepted in a line-latch cycle
  assert_latch_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    line_latch |-> !take);
endmodule

// File: tb/tb_col_line_capture.sv
module tb_col_line_capture;
  logic clk = 0, rst = 1, line_latch = 0, chip_en_in = 0, data_stb = 0;
  logic wide_mode = 1, rev_dir = 0;
  logic [7:0] din = 0;
  logic cascade_out;
  logic [159:0] line_q;
  logic [159:0] exp_buf;
  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  col_line_capture dut (.*);

  function automatic int boff(int k, bit rv);
    int g = rv ? 9 - k / 2 : k / 2;
    return g * 16 + (k % 2) * 8;
  endfunction

  task automatic chk1(string req, logic act, logic expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", req, act, expv);
    end
  endtask

  task automatic chkl(string req, logic [159:0] act, logic [159:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_latch;
    line_latch = 1; tick; line_latch = 0;
  endtask

  task automatic strobe(logic [7:0] d);
    din = d; data_stb = 1; tick; data_stb = 0; din = 8'h00;
  endtask

  task automatic send_byte(logic [7:0] b);
    if (wide_mode) strobe(b);
    else begin
      strobe({4'hA, b[3:0]});
      strobe({4'h5, b[7:4]});
    end
  endtask

  // sends a full line, checks cascade timing; updates exp_buf
  task automatic send_line(bit wm, bit rv, string req, bit gaps);
    logic [7:0] b;
    wide_mode = wm; rev_dir = rv;
    pulse_latch;
    chip_en_in = 1;
    for (int k = 0; k < 20; k++) begin
      b = 8'($urandom);
      send_byte(b);
      exp_buf[boff(k, rv) +: 8] = b;
      if (k == 18) chk1({req, " R6 no early cascade"}, cascade_out, 1'b0);
      if (gaps && ($urandom % 3 == 0)) tick;
    end
    chk1({req, " R6 cascade"}, cascade_out, 1'b1);
    chip_en_in = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=<100000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1234));
    exp_buf = '0;
    @(negedge clk); tick; rst = 0; tick;
    chk1("R1 cascade", cascade_out, 1'b0);
    chkl("R1 line", line_q, '0);

    // R7: strobes before any line latch ignored
    chip_en_in = 1; strobe(8'hFF); strobe(8'hEE); chip_en_in = 0;

    // R2 + R4 wide forward
    send_line(1, 0, "R2 R4", 0);
    // R6: strobes after completion ignored
    strobe(8'h11); strobe(8'h22);
    pulse_latch;
    chkl("R2 R4 R6 R7 line", line_q, exp_buf);

    // R3 + R5 narrow reverse
    send_line(0, 1, "R3 R5", 0);
    pulse_latch;
    chkl("R3 R5 line", line_q, exp_buf);

    // R7: armed, strobes without chip_en ignored; R10: drop enable mid-line
    wide_mode = 1; rev_dir = 0;
    pulse_latch;
    strobe(8'h99); strobe(8'h98);
    chk1("R7 no cascade", cascade_out, 1'b0);
    for (int k = 0; k < 20; k++) begin
      logic [7:0] b = 8'(k * 13 + 7);
      chip_en_in = (k == 0);
      send_byte(b);
      exp_buf[boff(k, 0) +: 8] = b;
    end
    chk1("R10 cascade", cascade_out, 1'b1);
    pulse_latch;
    chkl("R7 R10 line", line_q, exp_buf);
    chk1("R8 cascade cleared", cascade_out, 1'b0);

    // R8: stray half byte discarded by line latch; R9: strobe during latch
    wide_mode = 0; rev_dir = 0;
    chip_en_in = 1;
    strobe(8'h0C);           // half byte pending
    din = 8'hFF; data_stb = 1; line_latch = 1; tick;
    line_latch = 0; data_stb = 0;
    for (int k = 0; k < 20; k++) begin
      logic [7:0] b = 8'(8'hC3 ^ k);
      send_byte(b);
      exp_buf[boff(k, 0) +: 8] = b;
    end
    chk1("R8 R9 cascade", cascade_out, 1'b1);
    chip_en_in = 0;
    pulse_latch;
    chkl("R8 R9 line", line_q, exp_buf);

    // R8: line_q holds without a latch pulse
    wide_mode = 1; chip_en_in = 1;
    strobe(8'h77); strobe(8'h66);
    chkl("R8 hold", line_q, exp_buf);
    exp_buf[boff(0, 0) +: 8] = 8'h77;
    exp_buf[boff(1, 0) +: 8] = 8'h66;
    chip_en_in = 0;

    // random lines
    for (int n = 0; n < 8; n++) begin
      send_line(1'($urandom), 1'($urandom), "R4 R5 rnd", 1);
      pulse_latch;
      chkl("R2 R3 R4 R5 rnd line", line_q, exp_buf);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule